// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block is the exception-entry part of a RISC processor's system-control coprocessor. When the pipeline raises an entry strobe together with one or more fault requests, the block picks one winning fault. On that single clock edge it applies every architectural side effect of taking that fault: it writes the exception code and delay-slot flag, the return address, the faulting address and translation fields, and the shadow-register-set indices. It then presents the handler address and the next two sequential fetch addresses.

The handler address is built from the exception base, which is treated as 4 KB aligned. The offset is merged into the low 12 bits and depends on the fault kind, on the exception level that was already active, on the bootstrap-vector setting and on the vectored-interrupt setting. A reset request, or the asynchronous reset, puts the fetch addresses at the reset vector and marks coprocessor 1 usable. Return from exception, translation lookup and pipeline flushing belong to other blocks. The base, bootstrap, vectored-interrupt and exception-set values arrive as configuration inputs from the neighbouring control registers.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After the asynchronous reset, pcOut is 0xBFC00000, pcNext is 0xBFC00004, pcNextNext is 0xBFC00008, statusCu1 is 1, and statusExl, epc, causeExcCode and the shadow-set indices are 0.
- R2: The code written to causeExcCode for each request bit is: bit14 interrupt 0x0, bit7 TLB modified 0x1, bit3 load refill and bit5 load invalid 0x2, bit4 store refill and bit6 store invalid 0x3, bit1 load address error 0x4, bit2 store address error 0x5, bit8 syscall 0x8, bit9 breakpoint 0x9, bit10 reserved instruction 0xA, bit11 coprocessor unusable 0xB, bit12 overflow 0xC, bit13 trap 0xD. Bit0 is the reset request.
- R3: When several request bits are set, the lowest-numbered bit wins and only that fault updates state.
- R4: If pcIn+4 differs from nextPcIn, epc becomes pcIn-4 and causeBd becomes 1. Otherwise epc becomes pcIn and causeBd becomes 0.
- R5: Every taken non-reset fault sets statusExl. The previous set index takes the current one, and the current index takes cfgEss, only when statusExl and cfgBev were both 0 before entry.
- R6: Faults other than refill and interrupt go to the aligned base plus 0x180, whatever the state of cfgBev. The one exception is an overflow taken with cfgBev=1, which goes to 0xBFC00200.
- R7: A refill fault goes to the aligned base plus 0x000 if statusExl was 0 before entry, and to plus 0x180 if it was 1. Invalid faults always use plus 0x180.
- R8: An interrupt goes to the aligned base plus 0x200 when cfgIv is 1, and to plus 0x180 otherwise.
- R9: causeCe is cleared on every taken non-reset fault, except for coprocessor unusable, which loads coprocIdIn.
- R10: Address-error and TLB faults load badVAddr. TLB refill, invalid and modified faults also load the page-number, extension and ASID fields and contextBadVpn2. Every other fault leaves these registers unchanged.
- R11: After entry, pcOut is the handler address, pcNext is that address plus 4 and pcNextNext is that address plus 8.
- R12: A winning reset request sets the three PCs to the reset vector triplet and statusCu1 to 1, and changes no other register.
- R13: With excValid low, or with an empty request vector, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| excValid | input | 1 | Entry strobe |
| faultReq | input | 15 | Fault request bits (see R2) |
| pcIn | input | ADDR_W | PC of faulting instruction |
| nextPcIn | input | ADDR_W | Next PC at fault time |
| badVaIn | input | ADDR_W | Faulting virtual address |
| vpn2In | input | VPN2_W | Faulting page number |
| vpn2xIn | input | VPN2X_W | Page number extension |
| asidIn | input | ASID_W | Address-space ID |
| coprocIdIn | input | CE_W | Coprocessor that faulted |
| cfgEbase | input | ADDR_W | Exception base (low 12 bits ignored) |
| cfgBev | input | 1 | Bootstrap vector setting |
| cfgIv | input | 1 | Vectored interrupt setting |
| cfgEss | input | SRS_W | Shadow set for exceptions |
| pcOut | output | ADDR_W | Fetch PC |
| pcNext | output | ADDR_W | Fetch PC + 4 |
| pcNextNext | output | ADDR_W | Fetch PC + 8 |
| statusExl | output | 1 | Exception level |
| statusCu1 | output | 1 | Coprocessor 1 usable |
| causeExcCode | output | 5 | Exception code |
| causeBd | output | 1 | Delay-slot flag |
| causeCe | output | CE_W | Coprocessor error ID |
| epc | output | ADDR_W | Exception return address |
| badVAddr | output | ADDR_W | Bad virtual address |
| entryHiVpn2 | output | VPN2_W | Translation page number |
| entryHiVpn2x | output | VPN2X_W | Translation page extension |
| entryHiAsid | output | ASID_W | Translation ASID |
| contextBadVpn2 | output | VPN2_W | Context page number |
| srsCss | output | SRS_W | Current shadow set |
| srsPss | output | SRS_W | Previous shadow set |

## Verification
A table drives each fault kind once from a fresh reset, so every code and vector offset is seen with the exception level clear. The table also varies the sequential and branch-target next PC, which separates the two return-address forms, and toggles the bootstrap and vectored-interrupt settings, which separates the fixed overflow vector and the 0x200 interrupt offset from the general one. Multi-bit request patterns expose the winner order. Back-to-back entries show the refill offset and shadow-set swap changing once the exception level is set. Entries of other kinds in between show that the translation and coprocessor fields are left alone or cleared as required.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int NUM_KINDS = 15;
  localparam int KIND_W    = $clog2(NUM_KINDS);
  localparam int CODE_W    = 5;

  // bit position in the request vector == priority (lower wins)
  typedef enum logic [KIND_W-1:0] {
    K_RESET       = 4'd0,
    K_ADEL        = 4'd1,
    K_ADES        = 4'd2,
    K_TLBL_REFILL = 4'd3,
    K_TLBS_REFILL = 4'd4,
    K_TLBL_INV    = 4'd5,
    K_TLBS_INV    = 4'd6,
    K_TLB_MOD     = 4'd7,
    K_SYSCALL     = 4'd8,
    K_BREAK       = 4'd9,
    K_RESV        = 4'd10,
    K_CPU         = 4'd11,
    K_OVF         = 4'd12,
    K_TRAP        = 4'd13,
    K_INT         = 4'd14
  } faultKind_e;

  typedef struct packed {
    logic              take;
    logic              isReset;
    logic [CODE_W-1:0] excCode;
    logic              wrBadVa;
    logic              wrTlb;
    logic              isRefill;
    logic              isInt;
    logic              isCpu;
    logic              isOvf;
  } entryStrobe_t;

  function automatic logic [CODE_W-1:0] codeOf(faultKind_e k);
    case (k)
      K_INT:                     return 5'h00;
      K_TLB_MOD:                 return 5'h01;
      K_TLBL_REFILL, K_TLBL_INV: return 5'h02;
      K_TLBS_REFILL, K_TLBS_INV: return 5'h03;
      K_ADEL:                    return 5'h04;
      K_ADES:                    return 5'h05;
      K_SYSCALL:                 return 5'h08;
      K_BREAK:                   return 5'h09;
      K_RESV:                    return 5'h0A;
      K_CPU:                     return 5'h0B;
      K_OVF:                     return 5'h0C;
      K_TRAP:                    return 5'h0D;
      default:                   return 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
  import exc_entry_pkg::*;
(
  input  logic                 excValid,
  input  logic [NUM_KINDS-1:0] faultReq,
  output entryStrobe_t         strobe
);
  logic [KIND_W-1:0] winner;
  logic              anyReq;
  faultKind_e        kind;

  // scan from the lowest priority upward so the lowest index is left standing
  always_comb begin
    winner = '0;
    anyReq = 1'b0;
    for (int i = NUM_KINDS - 1; i >= 0; i--) begin
      if (faultReq[i]) begin
        winner = i[KIND_W-1:0];
        anyReq = 1'b1;
      end
    end
  end

  assign kind = faultKind_e'(winner);

  always_comb begin
    strobe          = '0;
    strobe.take     = excValid && anyReq;
    strobe.isReset  = (kind == K_RESET);
    strobe.excCode  = codeOf(kind);
    strobe.wrTlb    = (kind == K_TLBL_REFILL) || (kind == K_TLBS_REFILL) ||
                      (kind == K_TLBL_INV) || (kind == K_TLBS_INV) ||
                      (kind == K_TLB_MOD);
    strobe.wrBadVa  = strobe.wrTlb || (kind == K_ADEL) || (kind == K_ADES);
    strobe.isRefill = (kind == K_TLBL_REFILL) || (kind == K_TLBS_REFILL);
    strobe.isInt    = (kind == K_INT);
    strobe.isCpu    = (kind == K_CPU);
    strobe.isOvf    = (kind == K_OVF);
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          VPN2_W    = 19,
  parameter int          VPN2X_W   = 2,
  parameter int          ASID_W    = 8,
  parameter int          SRS_W     = 4,
  parameter int          CE_W      = 2,
  parameter int          PAGE_BITS = 12,
  parameter int          INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC   = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BOOT_OVF_VEC = 32'hBFC0_0200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  entryStrobe_t        strobe,
  input  logic [ADDR_W-1:0]   pcIn,
  input  logic [ADDR_W-1:0]   nextPcIn,
  input  logic [ADDR_W-1:0]   badVaIn,
  input  logic [VPN2_W-1:0]   vpn2In,
  input  logic [VPN2X_W-1:0]  vpn2xIn,
  input  logic [ASID_W-1:0]   asidIn,
  input  logic [CE_W-1:0]     coprocIdIn,
  input  logic [ADDR_W-1:0]   cfgEbase,
  input  logic                cfgBev,
  input  logic                cfgIv,
  input  logic [SRS_W-1:0]    cfgEss,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [ADDR_W-1:0]   pcNext,
  output logic [ADDR_W-1:0]   pcNextNext,
  output logic                statusExl,
  output logic                statusCu1,
  output logic [CODE_W-1:0]   causeExcCode,
  output logic                causeBd,
  output logic [CE_W-1:0]     causeCe,
  output logic [ADDR_W-1:0]   epc,
  output logic [ADDR_W-1:0]   badVAddr,
  output logic [VPN2_W-1:0]   entryHiVpn2,
  output logic [VPN2X_W-1:0]  entryHiVpn2x,
  output logic [ASID_W-1:0]   entryHiAsid,
  output logic [VPN2_W-1:0]   contextBadVpn2,
  output logic [SRS_W-1:0]    srsCss,
  output logic [SRS_W-1:0]    srsPss
);
  localparam logic [ADDR_W-1:0]    STEP      = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0]    STEP2     = ADDR_W'(2 * INSN_BYTES);
  localparam logic [PAGE_BITS-1:0] OFF_REFILL = PAGE_BITS'(12'h000);
  localparam logic [PAGE_BITS-1:0] OFF_GEN    = PAGE_BITS'(12'h180);
  localparam logic [PAGE_BITS-1:0] OFF_VINT   = PAGE_BITS'(12'h200);

  logic                 inSlot;
  logic [ADDR_W-1:0]    epcCalc;
  logic [PAGE_BITS-1:0] vecOff;
  logic [ADDR_W-1:0]    handler;
  logic                 swapSets;

  assign inSlot  = (pcIn + STEP) != nextPcIn;
  assign epcCalc = inSlot ? (pcIn - STEP) : pcIn;

  always_comb begin
    if (strobe.isRefill && !statusExl)   vecOff = OFF_REFILL;
    else if (strobe.isInt && cfgIv)      vecOff = OFF_VINT;
    else                                 vecOff = OFF_GEN;
  end

  // base is page aligned: the offset replaces the low bits, no carry upward
  always_comb begin
    if (strobe.isOvf && cfgBev) handler = BOOT_OVF_VEC;
    else handler = {cfgEbase[ADDR_W-1:PAGE_BITS], vecOff};
  end

  assign swapSets = !statusExl && !cfgBev;

  // fetch address triplet
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcOut      <= RESET_VEC;
      pcNext     <= RESET_VEC + STEP;
      pcNextNext <= RESET_VEC + STEP2;
    end else if (strobe.take) begin
      if (strobe.isReset) begin
        pcOut      <= RESET_VEC;
        pcNext     <= RESET_VEC + STEP;
        pcNextNext <= RESET_VEC + STEP2;
      end else begin
        pcOut      <= handler;
        pcNext     <= handler + STEP;
        pcNextNext <= handler + STEP2;
      end
    end
  end

  // status, cause, return address, shadow sets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusExl    <= 1'b0;
      statusCu1    <= 1'b1;
      causeExcCode <= '0;
      causeBd      <= 1'b0;
      causeCe      <= '0;
      epc          <= '0;
      srsCss       <= '0;
      srsPss       <= '0;
    end else if (strobe.take) begin
      if (strobe.isReset) begin
        statusCu1 <= 1'b1;
      end else begin
        if (swapSets) begin
          srsPss <= srsCss;
          srsCss <= cfgEss;
        end
        statusExl    <= 1'b1;
        epc          <= epcCalc;
        causeBd      <= inSlot;
        causeExcCode <= strobe.excCode;
        causeCe      <= strobe.isCpu ? coprocIdIn : '0;
      end
    end
  end

  // translation-related capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badVAddr       <= '0;
      entryHiVpn2    <= '0;
      entryHiVpn2x   <= '0;
      entryHiAsid    <= '0;
      contextBadVpn2 <= '0;
    end else if (strobe.take && !strobe.isReset) begin
      if (strobe.wrBadVa) badVAddr <= badVaIn;
      if (strobe.wrTlb) begin
        entryHiVpn2    <= vpn2In;
        entryHiVpn2x   <= vpn2xIn;
        entryHiAsid    <= asidIn;
        contextBadVpn2 <= vpn2In;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int VPN2_W  = 19,
  parameter int VPN2X_W = 2,
  parameter int ASID_W  = 8,
  parameter int SRS_W   = 4,
  parameter int CE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 excValid,
  input  logic [14:0]          faultReq,
  input  logic [ADDR_W-1:0]    pcIn,
  input  logic [ADDR_W-1:0]    nextPcIn,
  input  logic [ADDR_W-1:0]    badVaIn,
  input  logic [VPN2_W-1:0]    vpn2In,
  input  logic [VPN2X_W-1:0]   vpn2xIn,
  input  logic [ASID_W-1:0]    asidIn,
  input  logic [CE_W-1:0]      coprocIdIn,
  input  logic [ADDR_W-1:0]    cfgEbase,
  input  logic                 cfgBev,
  input  logic                 cfgIv,
  input  logic [SRS_W-1:0]     cfgEss,
  output logic [ADDR_W-1:0]    pcOut,
  output logic [ADDR_W-1:0]    pcNext,
  output logic [ADDR_W-1:0]    pcNextNext,
  output logic                 statusExl,
  output logic                 statusCu1,
  output logic [4:0]           causeExcCode,
  output logic                 causeBd,
  output logic [CE_W-1:0]      causeCe,
  output logic [ADDR_W-1:0]    epc,
  output logic [ADDR_W-1:0]    badVAddr,
  output logic [VPN2_W-1:0]    entryHiVpn2,
  output logic [VPN2X_W-1:0]   entryHiVpn2x,
  output logic [ASID_W-1:0]    entryHiAsid,
  output logic [VPN2_W-1:0]    contextBadVpn2,
  output logic [SRS_W-1:0]     srsCss,
  output logic [SRS_W-1:0]     srsPss
);
  entryStrobe_t strobe;

  exc_entry_ctl u_ctl (
    .excValid (excValid),
    .faultReq (faultReq),
    .strobe   (strobe)
  );

  exc_entry_dp #(
    .ADDR_W  (ADDR_W),
    .VPN2_W  (VPN2_W),
    .VPN2X_W (VPN2X_W),
    .ASID_W  (ASID_W),
    .SRS_W   (SRS_W),
    .CE_W    (CE_W)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .pcIn           (pcIn),
    .nextPcIn       (nextPcIn),
    .badVaIn        (badVaIn),
    .vpn2In         (vpn2In),
    .vpn2xIn        (vpn2xIn),
    .asidIn         (asidIn),
    .coprocIdIn     (coprocIdIn),
    .cfgEbase       (cfgEbase),
    .cfgBev         (cfgBev),
    .cfgIv          (cfgIv),
    .cfgEss         (cfgEss),
    .pcOut          (pcOut),
    .pcNext         (pcNext),
    .pcNextNext     (pcNextNext),
    .statusExl      (statusExl),
    .statusCu1      (statusCu1),
    .causeExcCode   (causeExcCode),
    .causeBd        (causeBd),
    .causeCe        (causeCe),
    .epc            (epc),
    .badVAddr       (badVAddr),
    .entryHiVpn2    (entryHiVpn2),
    .entryHiVpn2x   (entryHiVpn2x),
    .entryHiAsid    (entryHiAsid),
    .contextBadVpn2 (contextBadVpn2),
    .srsCss         (srsCss),
    .srsPss         (srsPss)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int ADDR_W = 32,
  parameter int SRS_W  = 4,
  parameter int CE_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              excValid,
  input logic [14:0]       faultReq,
  input logic [ADDR_W-1:0] pcIn,
  input logic [ADDR_W-1:0] nextPcIn,
  input logic [ADDR_W-1:0] pcOut,
  input logic [ADDR_W-1:0] pcNext,
  input logic [ADDR_W-1:0] pcNextNext,
  input logic              statusExl,
  input logic              statusCu1,
  input logic [4:0]        causeExcCode,
  input logic              causeBd,
  input logic [CE_W-1:0]   causeCe,
  input logic [ADDR_W-1:0] epc,
  input logic [SRS_W-1:0]  srsCss,
  input logic [SRS_W-1:0]  srsPss
);
  logic takeFault;
  assign takeFault = excValid && (|faultReq) && !faultReq[0];

  AST_EXL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    takeFault |=> statusExl); // R5

  AST_SETS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && statusExl) |=> ($stable(srsCss) && $stable(srsPss))); // R5

  AST_PC_TRIPLET: assert property (@(posedge clk) disable iff (!rst_n)
    (pcNext == pcOut + ADDR_W'(4)) && (pcNextNext == pcOut + ADDR_W'(8))); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !excValid |=> ($stable(pcOut) && $stable(epc) && $stable(causeExcCode) && $stable(statusExl))); // R13

  AST_DELAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    takeFault |=> (causeBd == ($past(pcIn) + ADDR_W'(4) != $past(nextPcIn)))); // R4

  AST_CE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (takeFault && !faultReq[11]) |=> (causeCe == '0)); // R9

  AST_CU1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    statusCu1); // R1
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W), .SRS_W(SRS_W), .CE_W(CE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .excValid     (excValid),
  .faultReq     (faultReq),
  .pcIn         (pcIn),
  .nextPcIn     (nextPcIn),
  .pcOut        (pcOut),
  .pcNext       (pcNext),
  .pcNextNext   (pcNextNext),
  .statusExl    (statusExl),
  .statusCu1    (statusCu1),
  .causeExcCode (causeExcCode),
  .causeBd      (causeBd),
  .causeCe      (causeCe),
  .epc          (epc),
  .srsCss       (srsCss),
  .srsPss       (srsPss)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        excValid = 1'b0;
  logic [14:0] faultReq = '0;
  logic [31:0] pcIn = '0, nextPcIn = '0, badVaIn = '0, cfgEbase = 32'h8000_3ABC;
  logic [18:0] vpn2In = '0;
  logic [1:0]  vpn2xIn = '0, coprocIdIn = '0;
  logic [7:0]  asidIn = '0;
  logic        cfgBev = 1'b0, cfgIv = 1'b0;
  logic [3:0]  cfgEss = '0;
  logic [31:0] pcOut, pcNext, pcNextNext, epc, badVAddr;
  logic        statusExl, statusCu1, causeBd;
  logic [4:0]  causeExcCode;
  logic [1:0]  causeCe, entryHiVpn2x;
  logic [18:0] entryHiVpn2, contextBadVpn2;
  logic [7:0]  entryHiAsid;
  logic [3:0]  srsCss, srsPss;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (.*);

  typedef struct packed {
    logic [14:0] req;
    logic [31:0] pc;
    logic [31:0] npc;
    logic        bev;
    logic        iv;
    logic [31:0] handler;
    logic [4:0]  code;
    logic        bd;
    logic [31:0] epcExp;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{15'h0100, 32'h0000_1000, 32'h0000_1004, 1'b0, 1'b0, 32'h8000_3180, 5'h08, 1'b0, 32'h0000_1000},
    '{15'h0200, 32'h0000_2000, 32'h0000_3000, 1'b0, 1'b0, 32'h8000_3180, 5'h09, 1'b1, 32'h0000_1FFC},
    '{15'h4000, 32'h0000_2100, 32'h0000_2104, 1'b0, 1'b1, 32'h8000_3200, 5'h00, 1'b0, 32'h0000_2100},
    '{15'h4000, 32'h0000_2200, 32'h0000_2204, 1'b0, 1'b0, 32'h8000_3180, 5'h00, 1'b0, 32'h0000_2200},
    '{15'h1000, 32'h0000_2300, 32'h0000_2304, 1'b1, 1'b0, 32'hBFC0_0200, 5'h0C, 1'b0, 32'h0000_2300},
    '{15'h1000, 32'h0000_2400, 32'h0000_2404, 1'b0, 1'b0, 32'h8000_3180, 5'h0C, 1'b0, 32'h0000_2400},
    '{15'h0008, 32'h0000_2500, 32'h0000_2504, 1'b0, 1'b0, 32'h8000_3000, 5'h02, 1'b0, 32'h0000_2500},
    '{15'h0040, 32'h0000_2600, 32'h0000_2604, 1'b0, 1'b0, 32'h8000_3180, 5'h03, 1'b0, 32'h0000_2600},
    '{15'h0080, 32'h0000_2700, 32'h0000_2800, 1'b0, 1'b0, 32'h8000_3180, 5'h01, 1'b1, 32'h0000_26FC},
    '{15'h0004, 32'h0000_2900, 32'h0000_2904, 1'b0, 1'b0, 32'h8000_3180, 5'h05, 1'b0, 32'h0000_2900},
    '{15'h0400, 32'h0000_2A00, 32'h0000_2A04, 1'b0, 1'b0, 32'h8000_3180, 5'h0A, 1'b0, 32'h0000_2A00},
    '{15'h2000, 32'h0000_2B00, 32'h0000_2B04, 1'b0, 1'b0, 32'h8000_3180, 5'h0D, 1'b0, 32'h0000_2B00},
    '{15'h4102, 32'h0000_2C00, 32'h0000_2C04, 1'b0, 1'b0, 32'h8000_3180, 5'h04, 1'b0, 32'h0000_2C00},
    '{15'h0100, 32'h0000_2D00, 32'h0000_2D04, 1'b1, 1'b0, 32'h8000_3180, 5'h08, 1'b0, 32'h0000_2D00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a falling edge; returns at the falling edge after the capture edge
  task automatic doEntry(input logic [14:0] req, input logic [31:0] pc, input logic [31:0] npc);
    faultReq = req;
    pcIn     = pc;
    nextPcIn = npc;
    excValid = 1'b1;
    @(negedge clk);
    excValid = 1'b0;
    faultReq = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] heldPc;
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 pcOut", pcOut, 32'hBFC0_0000);
    chk("R1 pcNext", pcNext, 32'hBFC0_0004);
    chk("R1 pcNextNext", pcNextNext, 32'hBFC0_0008);
    chk("R1 cu1", {31'd0, statusCu1}, 32'd1);
    chk("R1 exl", {31'd0, statusExl}, 32'd0);
    chk("R1 epc", epc, 32'd0);
    chk("R1 code", {27'd0, causeExcCode}, 32'd0);
    chk("R1 css", {28'd0, srsCss}, 32'd0);

    // table walk: R2 R3 R4 R6 R7 R8 R11, each from reset
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      cfgBev = VECS[v].bev;
      cfgIv  = VECS[v].iv;
      doEntry(VECS[v].req, VECS[v].pc, VECS[v].npc);
      chk("R6 R7 R8 handler", pcOut, VECS[v].handler);
      chk("R11 pcNext", pcNext, VECS[v].handler + 32'd4);
      chk("R11 pcNextNext", pcNextNext, VECS[v].handler + 32'd8);
      chk("R2 R3 code", {27'd0, causeExcCode}, {27'd0, VECS[v].code});
      chk("R4 bd", {31'd0, causeBd}, {31'd0, VECS[v].bd});
      chk("R4 epc", epc, VECS[v].epcExp);
      cfgBev = 1'b0;
      cfgIv  = 1'b0;
    end

    // R7 refill with exception level already set
    doReset();
    doEntry(15'h0100, 32'h100, 32'h104);
    doEntry(15'h0010, 32'h4000, 32'h4004);
    chk("R7 refill exl1", pcOut, 32'h8000_3180);
    chk("R2 store refill code", {27'd0, causeExcCode}, 32'h3);

    // R5 shadow sets
    doReset();
    cfgEss = 4'd5;
    doEntry(15'h0100, 32'h100, 32'h104);
    chk("R5 css swap", {28'd0, srsCss}, 32'd5);
    chk("R5 pss swap", {28'd0, srsPss}, 32'd0);
    chk("R5 exl set", {31'd0, statusExl}, 32'd1);
    cfgEss = 4'd7;
    doEntry(15'h0100, 32'h200, 32'h204);
    chk("R5 css held exl", {28'd0, srsCss}, 32'd5);
    doReset();
    cfgBev = 1'b1;
    cfgEss = 4'd6;
    doEntry(15'h0100, 32'h100, 32'h104);
    chk("R5 css held bev", {28'd0, srsCss}, 32'd0);
    cfgBev = 1'b0;

    // R9 coprocessor id
    doReset();
    coprocIdIn = 2'd2;
    doEntry(15'h0800, 32'h300, 32'h304);
    chk("R9 ce loaded", {30'd0, causeCe}, 32'd2);
    chk("R2 cpu code", {27'd0, causeExcCode}, 32'hB);
    doEntry(15'h0100, 32'h400, 32'h404);
    chk("R9 ce cleared", {30'd0, causeCe}, 32'd0);

    // R10 translation capture
    doReset();
    badVaIn = 32'hDEAD_0000; vpn2In = 19'h01234; vpn2xIn = 2'd1; asidIn = 8'h5A;
    doEntry(15'h0020, 32'h500, 32'h504);
    chk("R10 badva", badVAddr, 32'hDEAD_0000);
    chk("R10 vpn2", {13'd0, entryHiVpn2}, 32'h1234);
    chk("R10 vpn2x", {30'd0, entryHiVpn2x}, 32'd1);
    chk("R10 asid", {24'd0, entryHiAsid}, 32'h5A);
    chk("R10 context", {13'd0, contextBadVpn2}, 32'h1234);
    badVaIn = 32'h1111_1111; vpn2In = 19'h00777;
    doEntry(15'h0100, 32'h600, 32'h604);
    chk("R10 badva kept", badVAddr, 32'hDEAD_0000);
    chk("R10 vpn2 kept", {13'd0, entryHiVpn2}, 32'h1234);
    badVaIn = 32'h0000_0077;
    doEntry(15'h0002, 32'h700, 32'h704);
    chk("R10 adel badva", badVAddr, 32'h77);
    chk("R10 adel vpn2 kept", {13'd0, entryHiVpn2}, 32'h1234);

    // R13 no strobe / empty request
    heldPc = pcOut;
    faultReq = 15'h0100;
    pcIn = 32'h900; nextPcIn = 32'hA00;
    @(negedge clk);
    @(negedge clk);
    faultReq = '0;
    chk("R13 pc no strobe", pcOut, heldPc);
    chk("R13 code no strobe", {27'd0, causeExcCode}, 32'h4);
    doEntry(15'h0000, 32'h900, 32'hA00);
    chk("R13 pc empty req", pcOut, heldPc);
    chk("R13 epc empty req", epc, 32'h700);

    // R12 reset request wins and touches only PCs and CU1
    doEntry(15'h0101, 32'hB00, 32'hB04);
    chk("R12 pc", pcOut, 32'hBFC0_0000);
    chk("R12 pcNext", pcNext, 32'hBFC0_0004);
    chk("R12 code kept", {27'd0, causeExcCode}, 32'h4);
    chk("R12 exl kept", {31'd0, statusExl}, 32'd1);
    chk("R12 epc kept", epc, 32'h700);
    chk("R12 cu1", {31'd0, statusCu1}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule